// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches one T1/E1 receive channel and decides when the line has gone dead and when it has come back. Once per pulse interval, a valid strobe arrives together with a mark bit. The mark bit says whether the line pulse in that interval crossed the analog threshold. From this stream the block declares loss-of-signal (LOS) and later withdraws it. It applies one of three criteria: an E1 short-window rule, an E1 long-window rule, or a T1 rule. A two-bit mode input selects the criterion.

The LOS flag is registered. A second registered output steers a downstream glitch-free clock switch. While LOS is active it selects the reference clock, and once LOS has cleared it hands control back to the recovered clock. A change of mode restarts the detector from a clean, no-LOS state.

Top module: `los_monitor`

## Requirements
- R1: A zero-run count advances on each valid interval without a mark, returns to zero on each valid interval with a mark, and saturates instead of wrapping. For example, 20 zeros, then one mark, then 31 zeros leaves LOS low in mode 2'b00.
- R2: In mode 2'b00 (E1 short), LOS rises on the clock edge that takes in the 32nd consecutive zero interval. It stays low after 31 zero intervals.
- R3: In mode 2'b00, an active LOS clears on the edge of the interval after which the most recent 32 intervals hold at least 4 marks and contain no run of zeros longer than 15. A window with only 3 marks, or with a 16-zero run, keeps LOS active.
- R4: In mode 2'b01 (E1 long), LOS rises on the edge that takes in the 2048th consecutive zero interval. It stays low after 2047 zero intervals.
- R5: In mode 2'b01, an active LOS clears on the 33rd consecutive qualifying interval. An interval qualifies when it does not end a zero run of 2 or more, so a run of 2 zeros restarts the count. Both all marks and alternating mark/zero clear LOS on the 33rd interval.
- R6: In modes 2'b10 and 2'b11 (T1), LOS rises on the edge that takes in the 175th consecutive zero interval. It stays low after 174 zero intervals.
- R7: In T1 mode, while LOS is active, a mark opens a 175-interval window that includes that mark. At the window's last interval, LOS clears if the window held 22 or more marks. With 21 or fewer marks, LOS stays active and the next mark opens a new window.
- R8: The reference-clock select output rises on the same edge as LOS. It falls one clock after the edge on which LOS falls.
- R9: Reset forces LOS and clock select low. Any change of the mode input clears all detector state, and LOS reads low on the next clock.
- R10: Clock cycles with the valid strobe low do not advance any count and do not change LOS, whatever the mark input is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-side clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | One-cycle strobe per pulse interval |
| mark | input | 1 | Line pulse detected in this interval (sampled with valid) |
| mode | input | 2 | 00 E1 short, 01 E1 long, 10/11 T1 |
| los | output | 1 | Registered loss-of-signal flag |
| use_ref_clk | output | 1 | High selects the reference clock, low the recovered clock |

## Verification
The hardest situations to reach from the ports are the clear-side edge cases. One is an E1 short window that already holds enough marks but still contains a 16-zero run. Another is a T1 window that lands exactly one mark below the density limit. The stimulus first drives the detector into LOS with a long run of zeros. It then builds the window contents deliberately: three spaced marks against four, and three marks plus 16 zeros plus ones, so that the offending run or the missing mark is the only thing holding LOS. The bench then checks the exact interval on which the flag drops. In the E1 long mode, the 2048-zero declare is reached by brute force. The clear count is tested with alternating marks and with a double zero planted just before a clean streak.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic [1:0] {
        MODE_E1_SHORT = 2'b00,
        MODE_E1_LONG  = 2'b01,
        MODE_T1       = 2'b10,
        MODE_T1_ALT   = 2'b11
    } los_mode_e;

    typedef struct packed {
        logic valid;
        logic mark;
    } interval_t;

    function automatic logic is_t1(los_mode_e m);
        return (m == MODE_T1) || (m == MODE_T1_ALT);
    endfunction

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run
    import los_pkg::*;
#(
    parameter int unsigned MAX_RUN = 2048,
    localparam int unsigned W = $clog2(MAX_RUN + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  interval_t    iv,
    output logic [W-1:0] run_next,
    output logic [W-1:0] run
);

    always_comb begin
        run_next = run;
        if (iv.valid) begin
            if (iv.mark) begin
                run_next = '0;
            end else if (run != W'(MAX_RUN)) begin
                run_next = run + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            run <= '0;
        end else begin
            run <= run_next;
        end
    end

    AST_MARK_ZEROES_RUN: assert property (@(posedge clk) disable iff (rst)
        (iv.valid && iv.mark && !clr) |=> (run == '0)); // R1

    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (run == W'(MAX_RUN) && iv.valid && !iv.mark && !clr) |=> (run == W'(MAX_RUN))); // R1

endmodule

// File: rtl/los_density_window.sv
module los_density_window
    import los_pkg::*;
#(
    parameter int unsigned WIN = 32,
    localparam int unsigned CW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  interval_t     iv,
    output logic [CW-1:0] mark_cnt,
    output logic [CW-1:0] max_zero
);

    logic [WIN-1:0] hist;
    logic [WIN-1:0] hist_next;
    logic [CW-1:0]  cur_run;

    assign hist_next = iv.valid ? {hist[WIN-2:0], iv.mark} : hist;

    // Mark count and longest zero run of the window that includes this interval
    always_comb begin
        mark_cnt = '0;
        max_zero = '0;
        cur_run  = '0;
        for (int i = 0; i < WIN; i++) begin
            if (hist_next[i]) begin
                mark_cnt = mark_cnt + CW'(1);
                cur_run  = '0;
            end else begin
                cur_run = cur_run + CW'(1);
                if (cur_run > max_zero) begin
                    max_zero = cur_run;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hist <= '0;
        end else begin
            hist <= hist_next;
        end
    end

    AST_WIN_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (({1'b0, mark_cnt} + {1'b0, max_zero}) <= (CW + 1)'(WIN))); // R3

    AST_WIN_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!iv.valid && !clr) |=> $stable(hist)); // R10

endmodule

// File: rtl/los_mark_streak.sv
module los_mark_streak #(
    parameter int unsigned NEED  = 33,
    parameter int unsigned RUN_W = 12,
    localparam int unsigned SW = $clog2(NEED + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             valid,
    input  logic [RUN_W-1:0] run_next,
    output logic             reached
);

    logic [SW-1:0] streak;
    logic [SW-1:0] streak_next;

    always_comb begin
        streak_next = streak;
        if (valid) begin
            if (run_next >= RUN_W'(2)) begin
                streak_next = '0;
            end else if (streak != SW'(NEED)) begin
                streak_next = streak + SW'(1);
            end
        end
    end

    assign reached = valid && (streak_next == SW'(NEED));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            streak <= '0;
        end else begin
            streak <= streak_next;
        end
    end

    AST_STREAK_BREAK: assert property (@(posedge clk) disable iff (rst)
        (valid && run_next >= RUN_W'(2) && !clr) |=> (streak == '0)); // R5

endmodule

// File: rtl/los_pulse_window.sv
module los_pulse_window
    import los_pkg::*;
#(
    parameter int unsigned LEN       = 175,
    parameter int unsigned MIN_MARKS = 22,
    localparam int unsigned CW = $clog2(LEN + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      arm,
    input  interval_t iv,
    output logic      pass
);

    logic          active, active_next;
    logic [CW-1:0] cnt, cnt_next;
    logic [CW-1:0] marks, marks_next;

    always_comb begin
        active_next = active;
        cnt_next    = cnt;
        marks_next  = marks;
        pass        = 1'b0;
        if (!arm) begin
            active_next = 1'b0;
            cnt_next    = '0;
            marks_next  = '0;
        end else if (iv.valid) begin
            if (!active) begin
                if (iv.mark) begin
                    active_next = 1'b1;
                    cnt_next    = CW'(1);
                    marks_next  = CW'(1);
                end
            end else begin
                cnt_next   = cnt + CW'(1);
                marks_next = marks + CW'(iv.mark);
                if (cnt_next == CW'(LEN)) begin
                    active_next = 1'b0;
                    pass        = (marks_next >= CW'(MIN_MARKS));
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active <= 1'b0;
            cnt    <= '0;
            marks  <= '0;
        end else begin
            active <= active_next;
            cnt    <= cnt_next;
            marks  <= marks_next;
        end
    end

    AST_PW_MARKS_BOUND: assert property (@(posedge clk) disable iff (rst)
        (marks <= cnt) && (cnt <= CW'(LEN))); // R7

    AST_PW_DISARM: assert property (@(posedge clk) disable iff (rst)
        (!arm) |=> !active); // R7

endmodule

// File: rtl/los_monitor.sv
module los_monitor
    import los_pkg::*;
#(
    parameter int unsigned SHORT_ZEROS     = 32,
    parameter int unsigned SHORT_WIN       = 32,
    parameter int unsigned SHORT_MIN_MARKS = 4,
    parameter int unsigned SHORT_MAX_RUN   = 15,
    parameter int unsigned LONG_ZEROS      = 2048,
    parameter int unsigned LONG_STREAK     = 33,
    parameter int unsigned T1_ZEROS        = 175,
    parameter int unsigned T1_WIN          = 175,
    parameter int unsigned T1_MIN_MARKS    = 22
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       valid,
    input  logic       mark,
    input  logic [1:0] mode,
    output logic       los,
    output logic       use_ref_clk
);

    localparam int unsigned RUN_MAX0 = (SHORT_ZEROS > T1_ZEROS) ? SHORT_ZEROS : T1_ZEROS;
    localparam int unsigned RUN_MAX  = (LONG_ZEROS > RUN_MAX0) ? LONG_ZEROS : RUN_MAX0;
    localparam int unsigned RUN_W    = $clog2(RUN_MAX + 1);
    localparam int unsigned WCW      = $clog2(SHORT_WIN + 1);

    los_mode_e        mode_q;
    los_mode_e        mode_in;
    logic             mode_chg;
    interval_t        iv;
    logic [RUN_W-1:0] run_next, run;
    logic [WCW-1:0]   win_marks, win_max_zero;
    logic             streak_done;
    logic             t1_pass;
    logic             declare, release_ok, los_next;

    assign mode_in  = los_mode_e'(mode);
    assign mode_chg = (mode_in != mode_q);
    assign iv.valid = valid && !mode_chg;
    assign iv.mark  = mark;

    los_zero_run #(.MAX_RUN(RUN_MAX)) u_run (
        .clk(clk), .rst(rst), .clr(mode_chg), .iv(iv),
        .run_next(run_next), .run(run)
    );

    los_density_window #(.WIN(SHORT_WIN)) u_win (
        .clk(clk), .rst(rst), .clr(mode_chg), .iv(iv),
        .mark_cnt(win_marks), .max_zero(win_max_zero)
    );

    los_mark_streak #(.NEED(LONG_STREAK), .RUN_W(RUN_W)) u_streak (
        .clk(clk), .rst(rst), .clr(mode_chg), .valid(iv.valid),
        .run_next(run_next), .reached(streak_done)
    );

    los_pulse_window #(.LEN(T1_WIN), .MIN_MARKS(T1_MIN_MARKS)) u_t1win (
        .clk(clk), .rst(rst), .clr(mode_chg), .arm(los), .iv(iv),
        .pass(t1_pass)
    );

    always_comb begin
        unique case (mode_q)
            MODE_E1_SHORT: begin
                declare    = (run_next >= RUN_W'(SHORT_ZEROS));
                release_ok = (win_marks >= WCW'(SHORT_MIN_MARKS)) &&
                             (win_max_zero <= WCW'(SHORT_MAX_RUN));
            end
            MODE_E1_LONG: begin
                declare    = (run_next >= RUN_W'(LONG_ZEROS));
                release_ok = streak_done;
            end
            default: begin
                declare    = (run_next >= RUN_W'(T1_ZEROS));
                release_ok = t1_pass;
            end
        endcase
    end

    always_comb begin
        if (mode_chg) begin
            los_next = 1'b0;
        end else if (!los) begin
            los_next = iv.valid && declare;
        end else begin
            los_next = !(iv.valid && release_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            los         <= 1'b0;
            use_ref_clk <= 1'b0;
            mode_q      <= mode_in;
        end else begin
            los         <= los_next;
            use_ref_clk <= los_next || los;
            mode_q      <= mode_in;
        end
    end

    AST_SHORT_DECLARE: assert property (@(posedge clk) disable iff (rst)
        ($rose(los) && mode_q == MODE_E1_SHORT) |-> (run >= RUN_W'(SHORT_ZEROS))); // R2

    AST_SHORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($fell(los) && !$past(mode_chg) && mode_q == MODE_E1_SHORT)
            |-> ($past(win_marks) >= WCW'(SHORT_MIN_MARKS))); // R3

    AST_LONG_DECLARE: assert property (@(posedge clk) disable iff (rst)
        ($rose(los) && mode_q == MODE_E1_LONG) |-> (run >= RUN_W'(LONG_ZEROS))); // R4

    AST_T1_DECLARE: assert property (@(posedge clk) disable iff (rst)
        ($rose(los) && is_t1(mode_q)) |-> (run >= RUN_W'(T1_ZEROS))); // R6

    AST_REF_HELD_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(los) |-> use_ref_clk); // R8

    AST_REF_DROPS_LATER: assert property (@(posedge clk) disable iff (rst)
        (!los && $past(!los)) |-> !use_ref_clk); // R8

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !los); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!valid && !mode_chg) |=> $stable(los)); // R10

endmodule

// File: tb/los_monitor_bench.sv
module los_monitor_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid = 1'b0;
    logic       mark = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       los;
    logic       use_ref_clk;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    los_monitor u_los_monitor (
        .clk(clk), .rst(rst), .valid(valid), .mark(mark), .mode(mode),
        .los(los), .use_ref_clk(use_ref_clk)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // n intervals carrying bit m; returns at the negedge after the last valid edge
    task automatic send(input logic m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid = 1'b1;
            mark  = m;
            @(negedge clk);
            valid = 1'b0;
            mark  = 1'b0;
        end
    endtask

    task automatic idle(input int n, input logic m);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            mark = m;
        end
        @(negedge clk);
        mark = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(los, 1'b0, "R9 reset los");
        chk(use_ref_clk, 1'b0, "R9 reset use_ref_clk");
    endtask

    task automatic t_short_declare();
        send(1'b0, 20);
        send(1'b1, 1);
        send(1'b0, 31);
        chk(los, 1'b0, "R1 mark restarts zero run");
        idle(6, 1'b1);
        chk(los, 1'b0, "R10 idle cycles with mark high ignored");
        send(1'b0, 1);
        chk(los, 1'b1, "R2 declare at 32nd zero");
        chk(use_ref_clk, 1'b1, "R8 ref select rises with los");
    endtask

    task automatic t_short_clear_density();
        for (int k = 0; k < 3; k++) begin
            send(1'b1, 1);
            send(1'b0, 7);
        end
        chk(los, 1'b1, "R3 three marks keep los");
        send(1'b1, 1);
        chk(los, 1'b0, "R3 fourth mark clears los");
        chk(use_ref_clk, 1'b1, "R8 ref select held on clear edge");
        @(negedge clk);
        chk(use_ref_clk, 1'b0, "R8 ref select drops one clock later");
    endtask

    task automatic t_short_clear_run16();
        send(1'b0, 32);
        chk(los, 1'b1, "R2 redeclare at 32 zeros");
        send(1'b1, 3);
        send(1'b0, 16);
        send(1'b1, 13);
        chk(los, 1'b1, "R3 16-zero run in window keeps los");
        send(1'b1, 3);
        chk(los, 1'b1, "R3 run of 16 at window edge keeps los");
        send(1'b1, 1);
        chk(los, 1'b0, "R3 clears once longest run is 15");
    endtask

    task automatic t_mode_flush();
        send(1'b0, 32);
        chk(los, 1'b1, "R2 declare before mode change");
        set_mode(2'b01);
        chk(los, 1'b0, "R9 mode change clears los");
        @(negedge clk);
        chk(use_ref_clk, 1'b0, "R9 ref select low after flush");
    endtask

    task automatic t_long();
        send(1'b0, 2047);
        chk(los, 1'b0, "R4 no los at 2047 zeros");
        send(1'b0, 1);
        chk(los, 1'b1, "R4 declare at 2048 zeros");
        send(1'b1, 32);
        chk(los, 1'b1, "R5 32 marks keep los");
        send(1'b1, 1);
        chk(los, 1'b0, "R5 33rd mark clears los");
        send(1'b0, 2048);
        chk(los, 1'b1, "R4 redeclare");
        for (int k = 0; k < 10; k++) begin
            send(1'b1, 1);
            send(1'b0, 1);
        end
        send(1'b0, 1);
        send(1'b1, 32);
        chk(los, 1'b1, "R5 double zero restarts qualifying count");
        send(1'b1, 1);
        chk(los, 1'b0, "R5 clears 33 intervals after double zero");
        send(1'b0, 2048);
        for (int k = 0; k < 16; k++) begin
            send(1'b1, 1);
            send(1'b0, 1);
        end
        chk(los, 1'b1, "R5 32 alternating intervals keep los");
        send(1'b1, 1);
        chk(los, 1'b0, "R5 alternating pattern clears at 33rd");
    endtask

    task automatic t_t1();
        set_mode(2'b10);
        chk(los, 1'b0, "R9 los low after switch to T1");
        send(1'b0, 174);
        chk(los, 1'b0, "R6 no los at 174 zeros");
        send(1'b0, 1);
        chk(los, 1'b1, "R6 declare at 175 zeros");
        send(1'b1, 21);
        send(1'b0, 154);
        chk(los, 1'b1, "R7 21 marks in window keep los");
        send(1'b0, 10);
        chk(los, 1'b1, "R7 zeros open no window");
        send(1'b1, 22);
        send(1'b0, 152);
        chk(los, 1'b1, "R7 los held before window end");
        send(1'b0, 1);
        chk(los, 1'b0, "R7 22 marks clear at window end");
        @(negedge clk);
        chk(use_ref_clk, 1'b0, "R8 ref select released in T1");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_short_declare();
        t_short_clear_density();
        t_short_clear_run16();
        t_mode_flush();
        t_long();
        t_t1();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule